// File: doc/BRIEF.md
# Pretrigger Capture Sequencing Controller

This block runs one acquisition of a multi-channel logic capture into a circular sample buffer. Software sets a total window depth, counted in whole blocks of 512 samples, and a pretrigger depth. It also chooses which of two trigger units take part and how their hits combine, then pulses start. From then on the controller produces a write enable and a write address for every valid sample. The address runs around the buffer until a qualified trigger is seen. After the trigger it keeps writing until the posttrigger part of the window is full, and then it stops.

The buffer address of the trigger sample is latched. The controller also gives the address where readout of the window must begin, so the reader can unroll the ring in time order. A two-bit status code can be polled at any time. A restart input returns the engine to idle from any state. The trigger condition logic, the sample clock and the external memory control sit outside this block.

Top module: `capture_seq`

## Requirements
- R1: After reset, status_o is 0 (busy/idle), trig_addr_o and rd_start_o are 0, and wr_en_o stays low even when sample_vld_i is high.
- R2: A start is accepted only when all of these hold: state is idle or done, depth_blk_i lies in [MIN_BLK, 2^(ADDR_W-9)], and pre_i is less than depth_blk_i*512. Any other start is ignored: status stays 0 and no write occurs.
- R3: Once armed, each cycle with sample_vld_i high asserts wr_en_o in that same cycle. Writes go to consecutive addresses starting at 0, and the address after depth-1 is 0.
- R4: A hit on any of the first pre_i samples after arming is ignored.
- R5: The hit combine works as follows. With both units enabled and and_mode_i=0, either hit fires. With and_mode_i=1, both hits must be high on the same sample. With one unit enabled, only its hit counts. With neither enabled, the first eligible sample is the trigger.
- R6: trig_addr_o holds the buffer address of the trigger sample. rd_start_o equals (trig_addr_o − pre) mod depth.
- R7: The trigger sample and the samples after it total exactly depth − pre. After that, wr_en_o stays low.
- R8: status_o is 0 until the trigger sample is written, 1 while posttrigger samples are still due, and 2 once the window is complete. The value 2 holds until restart or a new start.
- R9: restart_i has priority over everything else. It suppresses wr_en_o in its own cycle. On the next cycle status_o, trig_addr_o and rd_start_o read 0.
- R10: A valid start issued while status is 2 re-arms a fresh capture with address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | sample clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| restart_i | input | 1 | synchronous engine restart |
| start_i | input | 1 | arm a capture with the presented configuration |
| depth_blk_i | input | ADDR_W-8 | window depth in 512-sample blocks |
| pre_i | input | ADDR_W+1 | pretrigger depth in samples |
| t1_en_i | input | 1 | trigger unit 1 enable |
| t2_en_i | input | 1 | trigger unit 2 enable |
| and_mode_i | input | 1 | 1: both hits required, 0: either hit |
| sample_vld_i | input | 1 | a sample is present this cycle |
| hit1_i | input | 1 | trigger unit 1 hit level for the current sample |
| hit2_i | input | 1 | trigger unit 2 hit level for the current sample |
| wr_en_o | output | 1 | buffer write enable |
| wr_addr_o | output | ADDR_W | buffer write address |
| trig_addr_o | output | ADDR_W | buffer address of the trigger sample |
| rd_start_o | output | ADDR_W | buffer address of the oldest sample in the window |
| status_o | output | 2 | 0 busy, 1 triggered, 2 done |

## Verification
The bench aims at several corner cases. Hits that arrive inside the pretrigger region are one: a design that accepts them stops early with a window short of history. The bench also sets a pretrigger of depth−1, which leaves a one-sample posttrigger; an off-by-one design there writes one sample too many or never reaches done. Windows that wrap the ring catch a wrong modulo in the write address or in rd_start_o. AND mode with staggered hits catches a design that fires on either hit. Restart in the middle of a capture and invalid starts catch engines that keep writing or report stale trigger addresses.

// File: rtl/cap_seq_pkg.sv
package cap_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_POST  = 2'd2,
    ST_DONE  = 2'd3
  } cap_state_e;

  localparam logic [1:0] STAT_BUSY = 2'd0;
  localparam logic [1:0] STAT_TRIG = 2'd1;
  localparam logic [1:0] STAT_DONE = 2'd2;

  function automatic logic [1:0] state_to_status(cap_state_e s);
    case (s)
      ST_POST: return STAT_TRIG;
      ST_DONE: return STAT_DONE;
      default: return STAT_BUSY;
    endcase
  endfunction
endpackage

// File: rtl/cap_trig_combine.sv
module cap_trig_combine (
  input  logic en1_i,
  input  logic en2_i,
  input  logic and_mode_i,
  input  logic hit1_i,
  input  logic hit2_i,
  output logic fire_o
);
  always_comb begin
    case ({en1_i, en2_i})
      2'b00:   fire_o = 1'b1;  // unconditional
      2'b10:   fire_o = hit1_i;
      2'b01:   fire_o = hit2_i;
      default: fire_o = and_mode_i ? (hit1_i & hit2_i) : (hit1_i | hit2_i);
    endcase
  end
endmodule

// File: rtl/cap_addr_ring.sv
module cap_addr_ring #(
  parameter int ADDR_W = 26
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] last_i,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_o <= '0;
    else if (clr_i)  addr_o <= '0;
    else if (adv_i)  addr_o <= (addr_o == last_i) ? '0 : addr_o + 1'b1;
  end

  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !clr_i && addr_o == last_i) |=> addr_o == '0);

  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !clr_i && addr_o != last_i) |=> addr_o == $past(addr_o) + 1'b1);
endmodule

// File: rtl/cap_seq_fsm.sv
module cap_seq_fsm
  import cap_seq_pkg::*;
#(
  parameter int ADDR_W  = 26,
  parameter int BLK_SH  = 9,
  parameter int MIN_BLK = 4,
  localparam int BLK_W  = ADDR_W - BLK_SH + 1,
  localparam int DEP_W  = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              start_i,
  input  logic [BLK_W-1:0]  depth_blk_i,
  input  logic [DEP_W-1:0]  pre_i,
  input  logic              t1_en_i,
  input  logic              t2_en_i,
  input  logic              and_mode_i,
  input  logic              sample_vld_i,
  input  logic              fire_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              en1_o,
  output logic              en2_o,
  output logic              and_o,
  output logic              wr_en_o,
  output logic              clr_o,
  output logic [ADDR_W-1:0] last_o,
  output logic [ADDR_W-1:0] trig_addr_o,
  output logic [ADDR_W-1:0] rd_start_o,
  output logic [1:0]        status_o
);
  localparam int MAX_BLK = 1 << (ADDR_W - BLK_SH);

  cap_state_e        state_q;
  logic [DEP_W-1:0]  depth_q, pre_q, fill_q, post_q;
  logic [ADDR_W-1:0] trig_q;

  logic [DEP_W-1:0] depth_in, post_init, trig_ext, back;
  logic cfg_ok, accept, wr, pre_met, running;

  assign depth_in  = {depth_blk_i, {BLK_SH{1'b0}}};
  assign cfg_ok    = (depth_blk_i >= BLK_W'(MIN_BLK)) && (depth_blk_i <= BLK_W'(MAX_BLK))
                     && (pre_i < depth_in);
  assign accept    = start_i && !restart_i && cfg_ok
                     && (state_q == ST_IDLE || state_q == ST_DONE);
  assign running   = (state_q == ST_ARMED) || (state_q == ST_POST);
  assign wr        = sample_vld_i && running && !restart_i;
  assign pre_met   = fill_q >= pre_q;
  assign post_init = depth_q - pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      depth_q <= '0;
      pre_q   <= '0;
      fill_q  <= '0;
      post_q  <= '0;
      trig_q  <= '0;
      en1_o   <= 1'b0;
      en2_o   <= 1'b0;
      and_o   <= 1'b0;
    end else if (restart_i) begin
      state_q <= ST_IDLE;
      depth_q <= '0;
      pre_q   <= '0;
      fill_q  <= '0;
      post_q  <= '0;
      trig_q  <= '0;
    end else if (accept) begin
      state_q <= ST_ARMED;
      depth_q <= depth_in;
      pre_q   <= pre_i;
      fill_q  <= '0;
      post_q  <= '0;
      trig_q  <= '0;
      en1_o   <= t1_en_i;
      en2_o   <= t2_en_i;
      and_o   <= and_mode_i;
    end else if (wr) begin
      if (state_q == ST_ARMED) begin
        if (pre_met && fire_i) begin
          trig_q  <= addr_i;
          post_q  <= post_init - 1'b1;
          state_q <= (post_init == DEP_W'(1)) ? ST_DONE : ST_POST;
        end else if (!pre_met) begin
          fill_q <= fill_q + 1'b1;
        end
      end else begin
        post_q <= post_q - 1'b1;
        if (post_q == DEP_W'(1)) state_q <= ST_DONE;
      end
    end
  end

  // oldest window sample, modulo depth
  always_comb begin
    trig_ext = {1'b0, trig_q};
    if (trig_ext < pre_q) back = trig_ext + depth_q - pre_q;
    else                  back = trig_ext - pre_q;
  end

  assign wr_en_o     = wr;
  assign clr_o       = accept || restart_i;
  assign last_o      = ADDR_W'(depth_q - DEP_W'(1));
  assign trig_addr_o = trig_q;
  assign rd_start_o  = ADDR_W'(back);
  assign status_o    = state_to_status(state_q);

  p_no_early_trig_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ARMED && wr_en_o && fill_q < pre_q) |=> state_q == ST_ARMED);

  p_post_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_POST) |-> (post_q != '0 && post_q < post_init));

  p_stop_after_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == STAT_DONE) |-> !wr_en_o);

  p_status_legal_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o != 2'd3);

  p_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (status_o == STAT_BUSY && trig_addr_o == '0 && !wr_en_o));

  p_rd_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE) |-> ({1'b0, rd_start_o} < depth_q));
endmodule

// File: rtl/capture_seq.sv
module capture_seq #(
  parameter int ADDR_W  = 26,
  parameter int BLK_SH  = 9,
  parameter int MIN_BLK = 4,
  localparam int BLK_W  = ADDR_W - BLK_SH + 1,
  localparam int DEP_W  = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              start_i,
  input  logic [BLK_W-1:0]  depth_blk_i,
  input  logic [DEP_W-1:0]  pre_i,
  input  logic              t1_en_i,
  input  logic              t2_en_i,
  input  logic              and_mode_i,
  input  logic              sample_vld_i,
  input  logic              hit1_i,
  input  logic              hit2_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [ADDR_W-1:0] trig_addr_o,
  output logic [ADDR_W-1:0] rd_start_o,
  output logic [1:0]        status_o
);
  logic en1, en2, and_m, fire, clr;
  logic [ADDR_W-1:0] last, addr;

  cap_trig_combine u_comb (
    .en1_i      (en1),
    .en2_i      (en2),
    .and_mode_i (and_m),
    .hit1_i     (hit1_i),
    .hit2_i     (hit2_i),
    .fire_o     (fire)
  );

  cap_addr_ring #(.ADDR_W(ADDR_W)) u_ring (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .adv_i  (wr_en_o),
    .last_i (last),
    .addr_o (addr)
  );

  cap_seq_fsm #(.ADDR_W(ADDR_W), .BLK_SH(BLK_SH), .MIN_BLK(MIN_BLK)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .restart_i    (restart_i),
    .start_i      (start_i),
    .depth_blk_i  (depth_blk_i),
    .pre_i        (pre_i),
    .t1_en_i      (t1_en_i),
    .t2_en_i      (t2_en_i),
    .and_mode_i   (and_mode_i),
    .sample_vld_i (sample_vld_i),
    .fire_i       (fire),
    .addr_i       (addr),
    .en1_o        (en1),
    .en2_o        (en2),
    .and_o        (and_m),
    .wr_en_o      (wr_en_o),
    .clr_o        (clr),
    .last_o       (last),
    .trig_addr_o  (trig_addr_o),
    .rd_start_o   (rd_start_o),
    .status_o     (status_o)
  );

  assign wr_addr_o = addr;

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 2'd2) |=> (!wr_en_o || $past(start_i)));

  p_and_both_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(status_o != 2'd0) && $past(en1 && en2 && and_m))
      |-> $past(hit1_i && hit2_i));
endmodule

// File: tb/capture_seq_tb_top.sv
`timescale 1ns/1ps
module capture_seq_tb_top;
  localparam int ADDR_W  = 11;
  localparam int MIN_BLK = 2;
  localparam int BLK_W   = ADDR_W - 9 + 1;
  localparam int DEP_W   = ADDR_W + 1;

  typedef struct packed {
    logic [BLK_W-1:0] blk;
    logic [11:0] pre;
    logic en1, en2, andm, gap;
    logic [11:0] h1lo, h1hi, h2lo, h2hi;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{3'd2, 12'd100,  1'b0,1'b0,1'b0,1'b0, 12'd0,   12'd0,   12'd0,   12'd0},
    '{3'd2, 12'd0,    1'b0,1'b0,1'b0,1'b1, 12'd0,   12'd0,   12'd0,   12'd0},
    '{3'd3, 12'd200,  1'b1,1'b0,1'b0,1'b1, 12'd500, 12'd500, 12'd300, 12'd300},
    '{3'd2, 12'd300,  1'b1,1'b1,1'b0,1'b0, 12'd100, 12'd100, 12'd400, 12'd410},
    '{3'd2, 12'd300,  1'b1,1'b1,1'b1,1'b0, 12'd350, 12'd360, 12'd360, 12'd370},
    '{3'd2, 12'd10,   1'b1,1'b1,1'b1,1'b1, 12'd20,  12'd700, 12'd600, 12'd600},
    '{3'd4, 12'd2047, 1'b0,1'b0,1'b0,1'b0, 12'd0,   12'd0,   12'd0,   12'd0},
    '{3'd2, 12'd1023, 1'b0,1'b1,1'b0,1'b1, 12'd0,   12'd0,   12'd1500,12'd1500},
    '{3'd3, 12'd0,    1'b1,1'b1,1'b0,1'b0, 12'd5,   12'd5,   12'd3,   12'd3}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic restart = 0, start = 0, t1_en = 0, t2_en = 0, and_mode = 0;
  logic vld = 0, hit1 = 0, hit2 = 0;
  logic [BLK_W-1:0] depth_blk = '0;
  logic [DEP_W-1:0] pre = '0;
  logic wr_en;
  logic [ADDR_W-1:0] wr_addr, trig_addr, rd_start;
  logic [1:0] status;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  capture_seq #(.ADDR_W(ADDR_W), .MIN_BLK(MIN_BLK)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .restart_i(restart), .start_i(start),
    .depth_blk_i(depth_blk), .pre_i(pre), .t1_en_i(t1_en), .t2_en_i(t2_en),
    .and_mode_i(and_mode), .sample_vld_i(vld), .hit1_i(hit1), .hit2_i(hit2),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .trig_addr_o(trig_addr),
    .rd_start_o(rd_start), .status_o(status)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit comb(vec_t v, int i);
    bit a = (i >= v.h1lo && i <= v.h1hi);
    bit b = (i >= v.h2lo && i <= v.h2hi);
    if (!v.en1 && !v.en2) return 1;
    if (v.en1 && !v.en2) return a;
    if (!v.en1 && v.en2) return b;
    return v.andm ? (a && b) : (a || b);
  endfunction

  task automatic run_vec(vec_t v, int vi);
    int depth = int'(v.blk) * 512;
    int k = -1, total, idx = 0, cyc = 0;
    int addr_err = 0, wr_err = 0, stat_err = 0, exp_st;
    for (int i = int'(v.pre); i < 4096 && k < 0; i++) if (comb(v, i)) k = i;
    total = k + depth - int'(v.pre);
    @(negedge clk);
    depth_blk = v.blk; pre = DEP_W'(v.pre);
    t1_en = v.en1; t2_en = v.en2; and_mode = v.andm; start = 1;
    @(negedge clk);
    start = 0;
    while (cyc < 20000) begin
      exp_st = (idx <= k) ? 0 : ((idx < total) ? 1 : 2);
      if (int'(status) != exp_st) stat_err++;
      if (idx == total) break;
      vld  = v.gap ? ((cyc % 4) != 3) : 1'b1;
      hit1 = vld && (idx >= v.h1lo && idx <= v.h1hi);
      hit2 = vld && (idx >= v.h2lo && idx <= v.h2hi);
      #1;
      if (wr_en != vld) wr_err++;
      if (wr_en && int'(wr_addr) != idx % depth) addr_err++;
      if (vld) idx++;
      cyc++;
      @(negedge clk);
    end
    vld = 0; hit1 = 0; hit2 = 0;
    $display("vector %0d: trigger sample %0d, window end %0d", vi, k, total);
    chk("R7/R10 samples written", idx, total);
    chk("R3 write address sequence errors", addr_err, 0);
    chk("R3 write enable errors", wr_err, 0);
    chk("R8 status sequence errors", stat_err, 0);
    chk("R6 trigger address", int'(trig_addr), k % depth);
    chk("R6 read start", int'(rd_start), (k - int'(v.pre)) % depth);
    vld = 1; #1;
    chk("R7 no write after done", int'(wr_en), 0);
    @(negedge clk); vld = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    vld = 1; #1;
    chk("R1 reset status", int'(status), 0);
    chk("R1 reset no write", int'(wr_en), 0);
    chk("R1 reset trig addr", int'(trig_addr), 0);
    chk("R1 reset read start", int'(rd_start), 0);
    @(negedge clk); vld = 0;

    // R2: invalid starts are ignored
    depth_blk = 3'd1; pre = '0; start = 1;
    @(negedge clk); start = 0; vld = 1; #1;
    chk("R2 depth below minimum no write", int'(wr_en), 0);
    @(negedge clk); vld = 0;
    depth_blk = 3'd4; pre = DEP_W'(2048); start = 1;
    @(negedge clk); start = 0; vld = 1; #1;
    chk("R2 pretrigger equal depth no write", int'(wr_en), 0);
    @(negedge clk); vld = 0;
    depth_blk = 3'd5; pre = '0; start = 1;
    @(negedge clk); start = 0; vld = 1; #1;
    chk("R2 depth above maximum no write", int'(wr_en), 0);
    chk("R2 status stays busy", int'(status), 0);
    @(negedge clk); vld = 0;

    // table-driven captures; every vector after the first re-arms from done (R10)
    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R9: restart during posttrigger fill
    depth_blk = 3'd2; pre = DEP_W'(4); t1_en = 0; t2_en = 0; start = 1;
    @(negedge clk); start = 0;
    for (int i = 0; i < 10; i++) begin vld = 1; @(negedge clk); end
    chk("R8 triggered status before restart", int'(status), 1);
    chk("R6 trigger address before restart", int'(trig_addr), 4);
    restart = 1; #1;
    chk("R9 restart blocks write", int'(wr_en), 0);
    @(negedge clk); restart = 0; #1;
    chk("R9 status after restart", int'(status), 0);
    chk("R9 trig addr after restart", int'(trig_addr), 0);
    chk("R9 read start after restart", int'(rd_start), 0);
    chk("R9 idle after restart no write", int'(wr_en), 0);
    @(negedge clk); vld = 0;

    // R10: re-arm after restart, first write lands at 0
    start = 1; @(negedge clk); start = 0; vld = 1; #1;
    chk("R10 first write enable", int'(wr_en), 1);
    chk("R10 first write address", int'(wr_addr), 0);
    @(negedge clk); vld = 0;

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule